// File: doc/BRIEF.md
# Variable-Length CAN Receive FIFO

This block is the receive store of a CAN controller. It takes one decoded frame at a time (identifier, extended and remote-request flags, an error flag, a data length and up to eight data bytes), packs it into a variable-length byte record and writes that record into a 64-byte circular buffer at one byte per clock. The record layout depends on the active register mode. The extended register mode uses a header byte followed by two or four identifier bytes. The basic register mode uses two control bytes that carry an 11-bit identifier.

A host reads the oldest record through a small byte window that is addressed relative to the read pointer. It frees that record with a release pulse. The release decodes the length of the head record from the record's own header bytes. The block keeps a message count and a byte count. It raises a one-cycle overrun pulse when a frame does not fit, and shows empty and not-empty flags. A pulse on the leave-reset input empties the store.

Top module: `can_rx_fifo`

## Requirements
- R1: With `ext_mode`=1, a stored record is laid out as follows. Byte 0 is a header: bit 7 holds the extended flag, bit 6 holds the RTR flag, bits 5:4 are 0 and bits 3:0 hold the length. An extended frame then has four id bytes: id[28:21], id[20:13], id[12:5], and id[4:0] in bits 7:3. A standard frame instead has two id bytes: id[10:3], and id[2:0] in bits 7:5. The data bytes come last. An RTR frame stores no data bytes.
- R2: With `ext_mode`=0, byte 0 of a record is id[10:3]. Byte 1 holds id[2:0] in bits 7:5, RTR in bit 4 and the length in bits 3:0. Then come `frm_len` data bytes, also for RTR frames.
- R3: An accepted frame is written one byte per clock. `wr_busy` stays high for exactly as many cycles as the record has bytes. When the last byte is written, `msg_cnt` rises by 1 and `byte_cnt` rises by the record length.
- R4: A release in extended mode removes 3 bytes, plus 2 if header bit 7 is set, plus the header length field if header bit 6 is clear. The read pointer advances by that amount modulo 64, `byte_cnt` falls by the same amount and `msg_cnt` falls by 1.
- R5: A release in basic mode removes 2 bytes plus bits 3:0 of the record's second byte, and `msg_cnt` falls by 1.
- R6: A release while `msg_cnt` is 0 changes neither count, and a later read of the window still starts at the same byte.
- R7: A frame is not stored if it has `frm_err` set, has `frm_len` above 8, or (in basic mode only) has `frm_ext` set. Such a frame changes no count and raises no overrun.
- R8: A storable frame whose record would push `byte_cnt` above 64 is dropped whole. It writes no byte, leaves both counts unchanged and raises `ovr_evt` for one cycle, in the cycle after it is offered. A record that brings `byte_cnt` to exactly 64 is stored.
- R9: `win_data` returns the byte at read pointer + `win_off`, wrapped modulo 64. It returns 0 when `win_off` is 13 or more in extended mode, or 10 or more in basic mode.
- R10: A `leave_reset` pulse clears both counts and aborts any record still being written. The next stored record then appears at window offset 0.
- R11: `empty` is 1 exactly when `msg_cnt` is 0, and `not_empty` is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | 1 = extended register mode record layout, 0 = basic |
| leave_reset | input | 1 | Pulse when the controller leaves reset mode; empties the store |
| frm_valid | input | 1 | Offers a frame; sampled while `wr_busy` is low |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_err | input | 1 | Frame is an error frame |
| frm_id | input | 29 | Identifier (standard frames use bits 10:0) |
| frm_len | input | 4 | Data length code |
| frm_data | input | 64 | Data bytes, byte i in bits 8i+7:8i |
| wr_busy | output | 1 | A record is being written |
| ovr_evt | output | 1 | One-cycle overrun pulse |
| rel_req | input | 1 | Release the head record |
| win_off | input | 4 | Byte offset into the receive window |
| win_data | output | 8 | Byte at read pointer + offset |
| msg_cnt | output | 7 | Stored record count |
| byte_cnt | output | 7 | Stored byte count |
| empty | output | 1 | No record stored |
| not_empty | output | 1 | At least one record stored |

## Verification
The hardest states to reach are the ones where the buffer is nearly full and a record crosses the end of the storage. There are two such cases: a frame that overshoots the capacity by a single byte, and a frame that fills it exactly. The bench reaches them through long sweeps of every flag and length combination, which release each record after checking it, so the pointers wrap several times with records split across the wrap point. Fill sequences with chosen lengths then land the byte count on 60, 63 and 64 before the next frame is offered. A `leave_reset` pulse is also driven while a record is half written.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

  localparam int REC_MAX = 13;
  localparam int WIN_EXT = 13;
  localparam int WIN_BAS = 10;

  // length of an extended-mode record from its first byte
  function automatic logic [4:0] ext_rec_span(input logic [7:0] hdr);
    logic [4:0] n;
    n = 5'd3;
    if (hdr[7]) n = n + 5'd2;
    if (!hdr[6]) n = n + {1'b0, hdr[3:0]};
    return n;
  endfunction

  // length of a basic-mode record from its second byte
  function automatic logic [4:0] bas_rec_span(input logic [7:0] ctl);
    return 5'd2 + {1'b0, ctl[3:0]};
  endfunction

  // number of payload bytes a frame stores
  function automatic logic [4:0] payload_count(input logic ext_mode, input logic rtr,
                                               input logic [3:0] len);
    return (ext_mode && rtr) ? 5'd0 : {1'b0, len};
  endfunction

endpackage

// File: rtl/can_rxq_packer.sv
module can_rxq_packer
  import can_rxq_pkg::*;
(
  input  logic                       ext_mode,
  input  logic                       frm_ext,
  input  logic                       frm_rtr,
  input  logic                       frm_err,
  input  logic [28:0]                frm_id,
  input  logic [3:0]                 frm_len,
  input  logic [63:0]                frm_data,
  output logic [REC_MAX-1:0][7:0]    rec_bytes,
  output logic [4:0]                 rec_len,
  output logic                       storable
);

  logic [3:0] base;
  logic [4:0] ndata;

  always_comb begin
    rec_bytes = '0;
    ndata     = payload_count(ext_mode, frm_rtr, frm_len);
    if (ext_mode) begin
      rec_bytes[0] = {frm_ext, frm_rtr, 2'b00, frm_len};
      if (frm_ext) begin
        rec_bytes[1] = frm_id[28:21];
        rec_bytes[2] = frm_id[20:13];
        rec_bytes[3] = frm_id[12:5];
        rec_bytes[4] = {frm_id[4:0], 3'b000};
        base = 4'd5;
      end else begin
        rec_bytes[1] = frm_id[10:3];
        rec_bytes[2] = {frm_id[2:0], 5'b00000};
        base = 4'd3;
      end
    end else begin
      rec_bytes[0] = frm_id[10:3];
      rec_bytes[1] = {frm_id[2:0], frm_rtr, frm_len};
      base = 4'd2;
    end
    for (int i = 0; i < 8; i++) begin
      if (5'(i) < ndata) rec_bytes[base + 4'(i)] = frm_data[8*i +: 8];
    end
    rec_len  = {1'b0, base} + ndata;
    storable = !frm_err && (frm_len <= 4'd8) && (ext_mode || !frm_ext);
  end

endmodule

// File: rtl/can_rxq_ram.sv
module can_rxq_ram #(
  parameter int DEPTH = 64,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [7:0]               wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][7:0]      rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
    end
  endgenerate

endmodule

// File: rtl/can_rxq_ctrl.sv
module can_rxq_ctrl
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_mode,
  input  logic                     leave_reset,
  input  logic                     frm_valid,
  input  logic                     storable,
  input  logic [REC_MAX-1:0][7:0]  rec_bytes,
  input  logic [4:0]               rec_len,
  input  logic                     rel_req,
  input  logic [7:0]               hdr0,
  input  logic [7:0]               hdr1,
  output logic                     ram_we,
  output logic [AW-1:0]            ram_waddr,
  output logic [7:0]               ram_wdata,
  output logic [AW-1:0]            rd_ptr,
  output logic [CW-1:0]            msg_cnt,
  output logic [CW-1:0]            byte_cnt,
  output logic                     wr_busy,
  output logic                     ovr_evt
);

  logic [REC_MAX-1:0][7:0] stage;
  logic [4:0]              stage_len;
  logic [4:0]              wr_idx;
  logic [AW-1:0]           wr_ptr;

  // named internal events
  logic [CW:0] need;
  logic        fit_ok, offer, acc_fire, ovr_hit, commit, rel_fire;
  logic [4:0]  rel_len;

  assign need     = (CW+1)'(byte_cnt) + (CW+1)'(rec_len);
  assign fit_ok   = need <= (CW+1)'(DEPTH);
  assign offer    = frm_valid && !wr_busy && !leave_reset && storable;
  assign acc_fire = offer && fit_ok;
  assign ovr_hit  = offer && !fit_ok;
  assign commit   = wr_busy && (wr_idx == stage_len - 5'd1);
  assign rel_len  = ext_mode ? ext_rec_span(hdr0) : bas_rec_span(hdr1);
  assign rel_fire = rel_req && (msg_cnt != '0) && !leave_reset;

  assign ram_we    = wr_busy;
  assign ram_waddr = wr_ptr + AW'(wr_idx);
  assign ram_wdata = stage[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage     <= '0;
      stage_len <= '0;
      wr_idx    <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      msg_cnt   <= '0;
      byte_cnt  <= '0;
      wr_busy   <= 1'b0;
      ovr_evt   <= 1'b0;
    end else if (leave_reset) begin
      msg_cnt   <= '0;
      byte_cnt  <= '0;
      wr_busy   <= 1'b0;
      wr_idx    <= '0;
      rd_ptr    <= wr_ptr;
      ovr_evt   <= 1'b0;
    end else begin
      ovr_evt <= ovr_hit;
      if (acc_fire) begin
        stage     <= rec_bytes;
        stage_len <= rec_len;
        wr_idx    <= '0;
        wr_busy   <= 1'b1;
      end else if (wr_busy) begin
        if (commit) begin
          wr_busy <= 1'b0;
          wr_ptr  <= wr_ptr + AW'(stage_len);
        end else begin
          wr_idx  <= wr_idx + 5'd1;
        end
      end
      msg_cnt  <= msg_cnt + CW'(commit) - CW'(rel_fire);
      byte_cnt <= byte_cnt + (commit ? CW'(stage_len) : '0)
                           - (rel_fire ? CW'(rel_len) : '0);
      if (rel_fire) rd_ptr <= rd_ptr + AW'(rel_len);
    end
  end

  assert_byte_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CW'(DEPTH));

  assert_overrun_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> !wr_busy);

  assert_empty_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && msg_cnt == '0 && !wr_busy && !leave_reset)
      |=> (msg_cnt == '0 && byte_cnt == $past(byte_cnt)));

  assert_commit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !rel_fire && !leave_reset) |=> msg_cnt == $past(msg_cnt) + CW'(1));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    leave_reset |=> (msg_cnt == '0 && byte_cnt == '0 && !wr_busy));

  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(frm_valid));

endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          leave_reset,
  input  logic          frm_valid,
  input  logic          frm_ext,
  input  logic          frm_rtr,
  input  logic          frm_err,
  input  logic [28:0]   frm_id,
  input  logic [3:0]    frm_len,
  input  logic [63:0]   frm_data,
  output logic          wr_busy,
  output logic          ovr_evt,
  input  logic          rel_req,
  input  logic [3:0]    win_off,
  output logic [7:0]    win_data,
  output logic [CW-1:0] msg_cnt,
  output logic [CW-1:0] byte_cnt,
  output logic          empty,
  output logic          not_empty
);

  logic [REC_MAX-1:0][7:0] rec_bytes;
  logic [4:0]              rec_len;
  logic                    storable;
  logic                    ram_we;
  logic [AW-1:0]           ram_waddr, rd_ptr;
  logic [7:0]              ram_wdata;
  logic [2:0][AW-1:0]      raddr;
  logic [2:0][7:0]         rdata;
  logic [3:0]              win_size;

  can_rxq_packer u_packer (
    .ext_mode (ext_mode),
    .frm_ext  (frm_ext),
    .frm_rtr  (frm_rtr),
    .frm_err  (frm_err),
    .frm_id   (frm_id),
    .frm_len  (frm_len),
    .frm_data (frm_data),
    .rec_bytes(rec_bytes),
    .rec_len  (rec_len),
    .storable (storable)
  );

  assign raddr[0] = rd_ptr + AW'(win_off);
  assign raddr[1] = rd_ptr;
  assign raddr[2] = rd_ptr + AW'(1);

  can_rxq_ram #(.DEPTH(DEPTH), .NRD(3)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(raddr),
    .rdata(rdata)
  );

  can_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .leave_reset(leave_reset),
    .frm_valid  (frm_valid),
    .storable   (storable),
    .rec_bytes  (rec_bytes),
    .rec_len    (rec_len),
    .rel_req    (rel_req),
    .hdr0       (rdata[1]),
    .hdr1       (rdata[2]),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .rd_ptr     (rd_ptr),
    .msg_cnt    (msg_cnt),
    .byte_cnt   (byte_cnt),
    .wr_busy    (wr_busy),
    .ovr_evt    (ovr_evt)
  );

  assign win_size  = ext_mode ? 4'(WIN_EXT) : 4'(WIN_BAS);
  assign win_data  = (win_off < win_size) ? rdata[0] : 8'h00;
  assign empty     = (msg_cnt == '0);
  assign not_empty = !empty;

  assert_basic_no_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !wr_busy && !ext_mode && (frm_ext || frm_err)) |=> (!wr_busy && !ovr_evt));

  assert_long_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !wr_busy && frm_len > 4'd8) |=> (!wr_busy && !ovr_evt));

endmodule

// File: tb/can_rx_fifo_bench.sv
module can_rx_fifo_bench;

  localparam int CAP = 64;

  logic        clk = 0, rst_n = 0;
  logic        ext_mode = 1, leave_reset = 0;
  logic        frm_valid = 0, frm_ext = 0, frm_rtr = 0, frm_err = 0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_len = '0;
  logic [63:0] frm_data = '0;
  logic        rel_req = 0;
  logic [3:0]  win_off = '0;
  logic        wr_busy, ovr_evt, empty, not_empty;
  logic [7:0]  win_data;
  logic [6:0]  msg_cnt, byte_cnt;

  can_rx_fifo u_can_rx_fifo (.*);

  always #5 clk = ~clk;

  typedef struct { int b [13]; int len; } rec_t;
  rec_t q[$];
  int   model_bytes = 0;
  int   checks = 0, failures = 0;
  bit   done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dbyte(input int id, input int len, input int i);
    return (id * 7 + i * 37 + len * 11) % 256;
  endfunction

  function automatic rec_t expect_rec(input bit m, input bit ext, input bit rtr,
                                      input int id, input int len);
    rec_t r; int base, nd;
    for (int k = 0; k < 13; k++) r.b[k] = 0;
    if (m) begin
      r.b[0] = ext * 128 + rtr * 64 + len;
      if (ext) begin
        r.b[1] = (id / (1 << 21)) % 256;
        r.b[2] = (id / (1 << 13)) % 256;
        r.b[3] = (id / 32) % 256;
        r.b[4] = (id % 32) * 8;
        base = 5;
      end else begin
        r.b[1] = (id / 8) % 256;
        r.b[2] = (id % 8) * 32;
        base = 3;
      end
      nd = rtr ? 0 : len;
    end else begin
      r.b[0] = (id / 8) % 256;
      r.b[1] = (id % 8) * 32 + rtr * 16 + len;
      base = 2;
      nd = len;
    end
    for (int k = 0; k < nd && k < 8; k++) r.b[base + k] = dbyte(id, len, k);
    r.len = base + nd;
    return r;
  endfunction

  task automatic check_counts(input string tag);
    chk({tag, " msg_cnt"}, int'(msg_cnt), q.size());
    chk({tag, " byte_cnt"}, int'(byte_cnt), model_bytes);
    chk("R11 empty flag", int'(empty), q.size() == 0);
    chk("R11 not_empty flag", int'(not_empty), q.size() != 0);
  endtask

  task automatic send(input bit ext, input bit rtr, input bit err, input int id,
                      input int len, input string tag);
    rec_t r; bit ok, fit; int n;
    r   = expect_rec(ext_mode, ext, rtr, id, len);
    ok  = !err && len <= 8 && (ext_mode || !ext);
    fit = (model_bytes + r.len) <= CAP;
    @(negedge clk);
    frm_ext = ext; frm_rtr = rtr; frm_err = err; frm_id = 29'(id); frm_len = 4'(len);
    for (int k = 0; k < 8; k++) frm_data[8*k +: 8] = 8'(dbyte(id, len, k));
    frm_valid = 1;
    @(negedge clk);
    frm_valid = 0;
    chk("R8 overrun pulse", int'(ovr_evt), int'(ok && !fit));
    n = 0;
    while (wr_busy) begin n++; @(negedge clk); end
    if (ok && fit) begin
      chk("R3 busy cycles", n, r.len);
      q.push_back(r);
      model_bytes += r.len;
    end else begin
      chk({tag, " no write"}, n, 0);
    end
    check_counts(tag);
  endtask

  task automatic check_head(input string tag);
    if (q.size() == 0) return;
    for (int k = 0; k < q[0].len; k++) begin
      win_off = 4'(k);
      #1;
      chk({tag, " window byte"}, int'(win_data), q[0].b[k]);
    end
    win_off = 0;
  endtask

  task automatic release_head(input string tag);
    @(negedge clk); rel_req = 1;
    @(negedge clk); rel_req = 0;
    if (q.size() > 0) begin
      model_bytes -= q[0].len;
      void'(q.pop_front());
    end
    check_counts(tag);
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) begin
      check_head(tag);
      release_head(tag);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_counts("R3 reset");
    chk("R3 reset busy", int'(wr_busy), 0);
    chk("R8 reset overrun", int'(ovr_evt), 0);

    // R6: release with nothing stored
    release_head("R6 empty release");

    // R1 R4 R9: extended mode sweep, pointers wrap many times
    ext_mode = 1;
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int l = 0; l <= 8; l++) begin
          int id;
          id = e ? ((29'h12345A7 + l * 4099 + r * 77) % (1 << 29)) : ((1029 + l * 97 + r * 5) % 2048);
          send(e[0], r[0], 1'b0, id, l, "R1");
          check_head("R1 R9");
          release_head("R4");
        end

    // R9: offsets beyond the extended window read 0
    send(1'b0, 1'b0, 1'b0, 1800, 8, "R1");
    for (int k = 13; k < 16; k++) begin
      win_off = 4'(k); #1;
      chk("R9 ext window limit", int'(win_data), 0);
    end
    win_off = 0;
    release_head("R4");
    release_head("R6 empty release");

    // R7 in extended mode
    send(1'b1, 1'b0, 1'b1, 5, 2, "R7 error frame");
    for (int l = 9; l < 16; l++) send(1'b1, 1'b0, 1'b0, 300, l, "R7 long frame");

    // R2 R5: basic mode sweep
    @(negedge clk); ext_mode = 0;
    for (int r = 0; r < 2; r++)
      for (int l = 0; l <= 8; l++) begin
        send(1'b0, r[0], 1'b0, (611 + l * 131 + r * 3) % 2048, l, "R2");
        check_head("R2 R9");
        release_head("R5");
      end

    send(1'b0, 1'b0, 1'b0, 42, 3, "R2");
    for (int k = 10; k < 16; k++) begin
      win_off = 4'(k); #1;
      chk("R9 basic window limit", int'(win_data), 0);
    end
    win_off = 0;
    release_head("R5");

    // R7 in basic mode
    send(1'b1, 1'b0, 1'b0, 1000, 4, "R7 extended in basic");
    send(1'b0, 1'b0, 1'b1, 1000, 4, "R7 error frame");
    send(1'b0, 1'b0, 1'b0, 1000, 12, "R7 long frame");

    // R8 basic: 6 x 10 = 60, 7th overruns, 4-byte record fills exactly 64
    for (int k = 0; k < 7; k++) send(1'b0, 1'b0, 1'b0, 100 + k * 9, 8, "R8 fill");
    send(1'b0, 1'b0, 1'b0, 77, 2, "R8 exact fit");
    chk("R8 full count", int'(byte_cnt), 64);
    send(1'b0, 1'b1, 1'b0, 78, 0, "R8 full");
    drain("R5");

    // R8 extended: 4 x 13 = 52, 5th overruns, standard 11 gives 63
    @(negedge clk); ext_mode = 1;
    for (int k = 0; k < 5; k++) send(1'b1, 1'b0, 1'b0, 29'h0ABCDEF + k * 333, 8, "R8 fill");
    send(1'b0, 1'b0, 1'b0, 1500, 8, "R8 near full");
    chk("R8 count 63", int'(byte_cnt), 63);
    send(1'b0, 1'b1, 1'b0, 1501, 5, "R8 over by 2");
    drain("R4");

    // R10: clear with records stored, then clear in mid-write
    send(1'b1, 1'b0, 1'b0, 29'h1F00F00, 6, "R10");
    send(1'b0, 1'b0, 1'b0, 700, 4, "R10");
    @(negedge clk); leave_reset = 1;
    @(negedge clk); leave_reset = 0;
    q.delete(); model_bytes = 0;
    check_counts("R10 clear");
    @(negedge clk);
    frm_ext = 1; frm_rtr = 0; frm_err = 0; frm_id = 29'h0123456; frm_len = 4'd8;
    frm_valid = 1;
    @(negedge clk); frm_valid = 0;
    repeat (3) @(negedge clk);
    leave_reset = 1;
    @(negedge clk); leave_reset = 0;
    chk("R10 abort busy", int'(wr_busy), 0);
    check_counts("R10 abort");
    send(1'b0, 1'b1, 1'b0, 333, 3, "R10 after clear");
    check_head("R10 head");
    release_head("R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule